// File: doc/BRIEF.md
# Switchable-Depth Receive Buffer

This block is the receive store of a serial port. The character decoder hands it 12-bit entries: 8 data bits with error or break bits above them. Software empties it one entry at a time through the data-register read strobe. A mode bit in the line control byte picks the depth at run time. With the bit set, the store is a 16-entry ring. With it clear, the store holds a single character.

The block keeps an empty flag and a full flag. It latches the error bits of the last entry read into a status register. It raises a receive interrupt level when the fill count reaches a trigger count, and drops it when a read brings the count back to one below the trigger. It tells the decoder whether another character can be taken. A break event stores a fixed break marker entry. Changing the mode bit discards the contents by zeroing the fill count and the read pointer.

The status flags are handled as sticky register bits, not as values decoded from the count. They move only on the events listed below.

Top module: `serial_rx_store`

## Requirements
- R1: After reset, `flags_o` reads 0x90, `level_o`, `lcr_o`, `rsr_o` and `rx_irq_o` are 0, and `ready_o` is 1.
- R2: Bit 4 of the line control byte selects ring mode with depth 16; when it is clear the depth is 1. `ready_o` is high exactly when `level_o` is below the current depth.
- R3: An accepted push stores its entry at slot (read pointer + level) mod 16, increments `level_o`, and clears the empty flag (`flags_o` bit 4).
- R4: In single mode every accepted push sets the full flag (`flags_o` bit 6). In ring mode a push sets it only when `level_o` becomes 16.
- R5: A push or break that arrives while `ready_o` is low is dropped, and level, flags, interrupt and contents stay unchanged.
- R6: `rd_data_o` always shows the entry at the read pointer. A read clears the full flag. If the level is non-zero, the read decrements it and advances the pointer mod 16. If the level is then zero, the read sets the empty flag.
- R7: `rx_irq_o` is set when the level after a push equals the trigger (1). It is cleared when the level after a read equals trigger minus one (0).
- R8: A read loads `rsr_o` with bits 11:8 of the entry it returned.
- R9: A break event (`brk_i`) pushes the entry 0x400, taking precedence over a simultaneous `push_i`.
- R10: A line control write that changes bit 4 zeroes the level and the read pointer but leaves flags, interrupt and stored entries alone. A write that keeps bit 4 keeps the level and pointer.
- R11: One operation per cycle, in the priority order line control write, read, break, push. The losing operations of that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Received-character strobe |
| push_data_i | input | 12 | Character with error bits |
| brk_i | input | 1 | Break event strobe |
| rd_i | input | 1 | Data-register read strobe |
| lcr_we_i | input | 1 | Line control write strobe |
| lcr_wdata_i | input | 8 | Line control write value |
| rd_data_o | output | 12 | Entry at the read pointer |
| rsr_o | output | 4 | Error bits of the last entry read |
| flags_o | output | 8 | Flags: bit 7 transmit empty, bit 6 full, bit 4 empty |
| lcr_o | output | 8 | Current line control byte |
| level_o | output | 5 | Fill count |
| ready_o | output | 1 | Can accept another character |
| rx_irq_o | output | 1 | Raw receive interrupt level |

## Verification
The bench builds the block with its defaults: depth 16, 12-bit entries, trigger 1, mode bit 4. These values let a few hundred cycles fill the ring completely and wrap the 4-bit read pointer several times. They also make single mode a one-entry case, so the drop-when-busy path and the full flag that is set on every push are hit constantly. With a trigger of 1, the interrupt set and clear thresholds fall on the empty/non-empty edge. Random mode toggles in the middle of traffic then expose the flags left stale by a flush.

// File: rtl/serial_rx_store.sv
module serial_rx_store #(
  parameter int DEPTH    = 16,
  parameter int ENTRY_W  = 12,
  parameter int TRIG     = 1,
  parameter int MODE_BIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] push_data_i,
  input  logic               brk_i,
  input  logic               rd_i,
  input  logic               lcr_we_i,
  input  logic [7:0]         lcr_wdata_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic [ENTRY_W-9:0] rsr_o,
  output logic [7:0]         flags_o,
  output logic [7:0]         lcr_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic               ready_o,
  output logic               rx_irq_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1 << 10);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PW-1:0] rptr;
  logic [CW-1:0] level;
  logic [7:0]    lcr_q;
  logic          empty_q, full_q, irq_q;
  logic [ENTRY_W-9:0] rsr_q;

  wire          ring_on = lcr_q[MODE_BIT];
  wire [CW-1:0] cap     = ring_on ? CW'(DEPTH) : CW'(1);
  wire          do_rd   = rd_i & ~lcr_we_i;
  wire          do_put  = (push_i | brk_i) & ~rd_i & ~lcr_we_i & ready_o;
  wire [ENTRY_W-1:0] put_val = brk_i ? BRK_ENTRY : push_data_i;
  wire [PW-1:0] wslot    = rptr + level[PW-1:0];
  wire [CW-1:0] level_up = level + CW'(1);
  wire [CW-1:0] level_dn = (level != '0) ? level - CW'(1) : level;

  assign ready_o   = level < cap;
  assign rd_data_o = mem[rptr];
  assign rsr_o     = rsr_q;
  assign flags_o   = {1'b1, full_q, 1'b0, empty_q, 4'b0000};
  assign lcr_o     = lcr_q;
  assign level_o   = level;
  assign rx_irq_o  = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_put) begin
      mem[wslot] <= put_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr    <= '0;
      level   <= '0;
      lcr_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      rsr_q   <= '0;
    end else if (lcr_we_i) begin
      if (lcr_wdata_i[MODE_BIT] != lcr_q[MODE_BIT]) begin
        rptr  <= '0;
        level <= '0;
      end
      lcr_q <= lcr_wdata_i;
    end else if (do_rd) begin
      full_q <= 1'b0;
      if (level != '0) begin
        level <= level_dn;
        rptr  <= rptr + PW'(1);
      end
      if (level_dn == '0) empty_q <= 1'b1;
      if (level_dn == CW'(TRIG - 1)) irq_q <= 1'b0;
      rsr_q <= rd_data_o[ENTRY_W-1:8];
    end else if (do_put) begin
      level   <= level_up;
      empty_q <= 1'b0;
      if (!ring_on || level_up == CW'(DEPTH)) full_q <= 1'b1;
      if (level_up == CW'(TRIG)) irq_q <= 1'b1;
    end
  end
endmodule

module serial_rx_store_chk #(
  parameter int DEPTH    = 16,
  parameter int ENTRY_W  = 12,
  parameter int TRIG     = 1,
  parameter int MODE_BIT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               push_i,
  input logic [ENTRY_W-1:0] push_data_i,
  input logic               brk_i,
  input logic               rd_i,
  input logic               lcr_we_i,
  input logic [7:0]         lcr_wdata_i,
  input logic [ENTRY_W-1:0] rd_data_o,
  input logic [ENTRY_W-9:0] rsr_o,
  input logic [7:0]         flags_o,
  input logic [7:0]         lcr_o,
  input logic [$clog2(DEPTH+1)-1:0] level_o,
  input logic               ready_o,
  input logic               rx_irq_o
);
  localparam int CW = $clog2(DEPTH + 1);
  wire put_req = (push_i | brk_i) & ~rd_i & ~lcr_we_i;

  p_single_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_o[MODE_BIT] |-> level_o <= CW'(1));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= CW'(DEPTH));

  p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (put_req && !ready_o) |=> $stable(level_o) && $stable(flags_o) && $stable(rx_irq_o));

  p_push_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (put_req && ready_o) |=> !flags_o[4] && level_o == $past(level_o) + CW'(1));

  p_ring_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (put_req && ready_o && lcr_o[MODE_BIT] && !flags_o[6] && level_o < CW'(DEPTH - 1))
      |=> !flags_o[6]);

  p_read_clears_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !lcr_we_i) |=> !flags_o[6]);

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (put_req && ready_o && level_o == CW'(TRIG - 1)) |=> rx_irq_o);

  p_rsr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !lcr_we_i) |=> rsr_o == $past(rd_data_o[ENTRY_W-1:8]));

  p_mode_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_we_i && lcr_wdata_i[MODE_BIT] != lcr_o[MODE_BIT]) |=> level_o == '0);

  p_lcr_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_we_i && lcr_wdata_i[MODE_BIT] == lcr_o[MODE_BIT]) |=> $stable(level_o) && $stable(flags_o));
endmodule

bind serial_rx_store serial_rx_store_chk #(
  .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .TRIG(TRIG), .MODE_BIT(MODE_BIT)
) u_chk (.*);

// File: tb/serial_rx_store_tb_top.sv
module serial_rx_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, brk_i = 1'b0, rd_i = 1'b0, lcr_we_i = 1'b0;
  logic [11:0] push_data_i = '0;
  logic [7:0]  lcr_wdata_i = '0;
  logic [11:0] rd_data_o;
  logic [3:0]  rsr_o;
  logic [7:0]  flags_o, lcr_o;
  logic [4:0]  level_o;
  logic        ready_o, rx_irq_o;

  always #10 clk = ~clk;

  serial_rx_store dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .brk_i(brk_i), .rd_i(rd_i), .lcr_we_i(lcr_we_i), .lcr_wdata_i(lcr_wdata_i),
    .rd_data_o(rd_data_o), .rsr_o(rsr_o), .flags_o(flags_o), .lcr_o(lcr_o),
    .level_o(level_o), .ready_o(ready_o), .rx_irq_o(rx_irq_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_mem [16];
  int m_rp, m_cnt, m_lcr, m_rsr;
  bit m_empty, m_full, m_irq;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int depth = (m_lcr & 'h10) ? 16 : 1;
    chk("R6 R9 rd_data", rd_data_o, m_mem[m_rp]);
    chk("R3 R4 R6 flags", flags_o, 'h80 | (m_full ? 'h40 : 0) | (m_empty ? 'h10 : 0));
    chk("R3 R5 R10 R11 level", level_o, m_cnt);
    chk("R2 ready", ready_o, m_cnt < depth);
    chk("R7 irq", rx_irq_o, m_irq);
    chk("R8 rsr", rsr_o, m_rsr);
    chk("R10 lcr", lcr_o, m_lcr);
  endtask

  task automatic model_step(bit p, int d, bit b, bit r, bit w, int wd);
    if (w) begin
      if ((m_lcr ^ wd) & 'h10) begin m_cnt = 0; m_rp = 0; end
      m_lcr = wd;
    end else if (r) begin
      int c = m_mem[m_rp];
      m_full = 0;
      if (m_cnt > 0) begin m_cnt--; m_rp = (m_rp + 1) % 16; end
      if (m_cnt == 0) m_empty = 1;
      if (m_cnt == 0) m_irq = 0;
      m_rsr = (c >> 8) & 'hf;
    end else if (b || p) begin
      bit ring = (m_lcr & 'h10) != 0;
      int depth = ring ? 16 : 1;
      if (m_cnt < depth) begin
        m_mem[(m_rp + m_cnt) % 16] = b ? 'h400 : d;
        m_cnt++;
        m_empty = 0;
        if (!ring || m_cnt == 16) m_full = 1;
        if (m_cnt == 1) m_irq = 1;
      end
    end
  endtask

  task automatic cyc(bit p, int d, bit b, bit r, bit w, int wd);
    push_i = p; push_data_i = 12'(d); brk_i = b; rd_i = r;
    lcr_we_i = w; lcr_wdata_i = 8'(wd);
    @(posedge clk);
    model_step(p, d, b, r, w, wd);
    @(negedge clk);
    push_i = 0; brk_i = 0; rd_i = 0; lcr_we_i = 0;
    compare_all();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    m_rp = 0; m_cnt = 0; m_lcr = 0; m_rsr = 0;
    m_empty = 1; m_full = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset flags", flags_o, 'h90);
    chk("R1 reset ready", ready_o, 1);
    compare_all();
    // single mode
    cyc(1, 'h0a5, 0, 0, 0, 0);
    cyc(1, 'h3cc, 0, 0, 0, 0);      // R5 dropped
    cyc(0, 0, 1, 0, 0, 0);          // R5 break dropped
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);          // R6 read on empty
    cyc(1, 'h155, 1, 0, 0, 0);      // R9 break wins
    cyc(0, 0, 0, 1, 0, 0);          // R8 rsr = 4
    cyc(1, 'h912, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    // ring mode
    cyc(0, 0, 0, 0, 1, 'h10);
    for (int i = 0; i < 17; i++) cyc(1, 'h100 + i, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 'h200 + i, 0, 0, 0, 0);
    cyc(1, 'h777, 0, 1, 0, 0);      // R11 read beats push
    cyc(1, 'h777, 1, 1, 1, 'h30);   // R10 R11 keep bit 4
    cyc(0, 0, 0, 0, 1, 'h00);       // R10 flush
    cyc(1, 'h0ee, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 'h10);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 600; i++) begin
      int rv = $urandom;
      bit w = (rv % 29) == 0;
      cyc((rv >> 5) % 2 == 1, (rv >> 8) & 'hfff, (rv >> 20) % 17 == 0,
          (rv >> 24) % 5 < 2, w, (rv >> 12) & 'hff);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule